// File: doc/BRIEF.md
# Configuration-to-User-Mode Wake Sequencer

This block carries a programmable device from its configuration state into user mode. It waits for an internal flag saying that the whole configuration image has arrived. It then steps through three timed phases that release the global controls in a fixed order: output enable, write protection for the embedded RAMs, and the global set/reset. After that it lets an open-drain done pin float high. User mode is entered only once that pin is seen high. Any other device on the board can therefore hold the pin low and delay the start.

The done pin appears as two signals. `done_release` is the output side: while it is low, the block pulls the pin low. `done_pin_in` is the pin's level as read back, and it passes through a two-flop synchroniser. The RAM write strobes of the fabric pass through the block, which masks them while write protection is active. A clear request returns the block to its pre-wake state from any state.

Top module: `wake_sequencer`

## Requirements
- R1: After reset, and until a start is sampled, the block holds the pre-wake state: gout_en=0, gwr_dis=0, gsr=1, done_release=0, user_mode=0.
- R2: A high `cfg_done` sampled in the pre-wake state starts phase one on the next clock edge. Phase one and phase two each last exactly PHASE_CYCLES cycles.
- R3: In phase one, gout_en=1, gwr_dis=1, gsr=1, done_release=0 and user_mode=0.
- R4: In phase two, gout_en=1, gwr_dis=0, gsr=0, done_release=0 and user_mode=0.
- R5: In phase three, gout_en=1, gwr_dis=0, gsr=0 and done_release=1. If the pin already reads high, user_mode goes to 1 exactly PHASE_CYCLES cycles after phase three begins.
- R6: `ram_we_out` equals `ram_we_in` bit for bit when gwr_dis=0, and is all zeros when gwr_dis=1.
- R7: While `done_pin_in` is held low, the block stays in phase three. After the pin rises, and once phase three has lasted at least PHASE_CYCLES cycles, user_mode goes to 1 on the third clock edge after the rise.
- R8: User mode is sticky: gout_en=1, gsr=0, gwr_dis=0, done_release=1 and user_mode=1 hold, and `cfg_done` has no effect there.
- R9: A high `clear_req` returns the block to the pre-wake outputs of R1 on the next edge from any state. It takes precedence over `cfg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done | input | 1 | Configuration image fully received |
| clear_req | input | 1 | Clear or re-initialise request |
| done_pin_in | input | 1 | Level read back from the open-drain done pin |
| done_release | output | 1 | 1 lets the done pin float high, 0 pulls it low |
| ram_we_in | input | RAM_PORTS | Write strobes from the fabric RAMs |
| ram_we_out | output | RAM_PORTS | Write strobes after write protection |
| gout_en | output | 1 | Global output enable (0 keeps I/O high-impedance) |
| gwr_dis | output | 1 | Global RAM write disable |
| gsr | output | 1 | Global set/reset |
| user_mode | output | 1 | Device is in user mode |

## Verification
All outputs are decoded straight from the state register, so a wrong state shows on the global controls in the same cycle. A phase counter that is off by one moves a control edge by one cycle, and this is seen the first time a phase boundary is reached. A missing or extra synchroniser stage moves user-mode entry by one cycle after the held pin is released. A fault in write masking shows at once on `ram_we_out`, because the input pattern changes every cycle.

// File: rtl/wake_sequencer.sv
module wake_sequencer #(
  parameter int PHASE_CYCLES = 8,
  parameter int RAM_PORTS    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_done,
  input  logic                 clear_req,
  input  logic                 done_pin_in,
  output logic                 done_release,
  input  logic [RAM_PORTS-1:0] ram_we_in,
  output logic [RAM_PORTS-1:0] ram_we_out,
  output logic                 gout_en,
  output logic                 gwr_dis,
  output logic                 gsr,
  output logic                 user_mode
);
  localparam int CW = $clog2(PHASE_CYCLES) + 1;

  typedef enum logic [2:0] {ST_CFG, ST_PH1, ST_PH2, ST_PH3, ST_USER} wake_st_t;

  wake_st_t      st, st_nx;
  logic [CW-1:0] cnt;
  logic          pin_s1, pin_s2;
  logic          last;

  assign last = (cnt == CW'(PHASE_CYCLES - 1));

  always_comb begin
    st_nx = st;
    if (clear_req) st_nx = ST_CFG;
    else begin
      case (st)
        ST_CFG: if (cfg_done)         st_nx = ST_PH1;
        ST_PH1: if (last)             st_nx = ST_PH2;
        ST_PH2: if (last)             st_nx = ST_PH3;
        ST_PH3: if (last && pin_s2)   st_nx = ST_USER;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CFG;
      cnt    <= '0;
      pin_s1 <= 1'b0;
      pin_s2 <= 1'b0;
    end else begin
      pin_s1 <= done_pin_in;
      pin_s2 <= pin_s1;
      st     <= st_nx;
      if (st_nx != st) cnt <= '0;
      else if (!last)  cnt <= cnt + 1'b1;
    end
  end

  assign gout_en      = (st != ST_CFG);
  assign gwr_dis      = (st == ST_PH1);
  assign gsr          = (st == ST_CFG) || (st == ST_PH1);
  assign done_release = (st == ST_PH3) || (st == ST_USER);
  assign user_mode    = (st == ST_USER);
  assign ram_we_out   = ram_we_in & ~{RAM_PORTS{gwr_dis}};

  assert_oe_under_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gout_en) |-> gsr && gwr_dis);

  assert_gsr_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gsr) |-> gout_en && !gwr_dis && $past(gwr_dis));

  assert_user_needs_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_mode) |-> $past(pin_s2) && done_release);

  assert_user_controls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    user_mode |-> gout_en && !gsr && !gwr_dis && done_release);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_req |=> gsr && !gout_en && !done_release && !user_mode);
endmodule

// File: tb/sim_wake_sequencer.sv
`timescale 1ns/1ps
module sim_wake_sequencer;
  localparam int P  = 8;
  localparam int RP = 4;

  localparam logic [4:0] E_IDLE = 5'b00100;
  localparam logic [4:0] E_PH1  = 5'b11100;
  localparam logic [4:0] E_PH2  = 5'b10000;
  localparam logic [4:0] E_PH3  = 5'b10010;
  localparam logic [4:0] E_USR  = 5'b10011;

  logic clk = 1'b0, rst_n = 1'b0, cfg_done = 1'b0, clear_req = 1'b0, ext_hold = 1'b0;
  logic done_pin_in, done_release, gout_en, gwr_dis, gsr, user_mode;
  logic [RP-1:0] ram_we_in = '0, ram_we_out, we_pat = 4'h5;

  logic [4+RP:0] exp_q[$];
  string         tag_q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign done_pin_in = done_release & ~ext_hold;

  wake_sequencer #(.PHASE_CYCLES(P), .RAM_PORTS(RP)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done(cfg_done), .clear_req(clear_req),
    .done_pin_in(done_pin_in), .done_release(done_release),
    .ram_we_in(ram_we_in), .ram_we_out(ram_we_out),
    .gout_en(gout_en), .gwr_dis(gwr_dis), .gsr(gsr), .user_mode(user_mode));

  task automatic push(input logic [4:0] v, input string tag);
    ram_we_in = we_pat;
    exp_q.push_back({v, v[3] ? {RP{1'b0}} : we_pat});
    tag_q.push_back(tag);
    we_pat = we_pat + 4'd3;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wake(input int hold);
    ext_hold = (hold > 0);
    cfg_done = 1'b1; push(E_IDLE, "R1"); step(); cfg_done = 1'b0;
    for (int i = 0; i < P; i++) begin push(E_PH1, "R2 R3 R6"); step(); end
    for (int i = 0; i < P; i++) begin push(E_PH2, "R2 R4 R6"); step(); end
    if (hold == 0) begin
      for (int i = 0; i < P; i++) begin push(E_PH3, "R5"); step(); end
    end else begin
      for (int i = 0; i < P + hold; i++) begin push(E_PH3, "R7"); step(); end
      ext_hold = 1'b0;
      for (int i = 0; i < 3; i++) begin push(E_PH3, "R7"); step(); end
    end
    for (int i = 0; i < 3; i++) begin push(E_USR, "R5 R7"); step(); end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [4+RP:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {gout_en, gwr_dis, gsr, done_release, user_mode, ram_we_out};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b", t, a, e);
      end
    end
  end

  initial begin
    #1600000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin push(E_IDLE, "R1"); step(); end
    wake(0);
    cfg_done = 1'b1;
    for (int i = 0; i < 3; i++) begin push(E_USR, "R8"); step(); end
    cfg_done = 1'b0;
    clear_req = 1'b1; push(E_USR, "R9"); step(); clear_req = 1'b0;
    for (int i = 0; i < 2; i++) begin push(E_IDLE, "R9"); step(); end
    wake(5);
    clear_req = 1'b1; push(E_USR, "R9"); step(); clear_req = 1'b0;
    push(E_IDLE, "R9"); step();
    clear_req = 1'b1; cfg_done = 1'b1; push(E_IDLE, "R9"); step();
    clear_req = 1'b0; cfg_done = 1'b0;
    push(E_IDLE, "R9"); step();
    cfg_done = 1'b1; push(E_IDLE, "R2"); step(); cfg_done = 1'b0;
    for (int i = 0; i < P; i++) begin push(E_PH1, "R3"); step(); end
    push(E_PH2, "R4"); step();
    clear_req = 1'b1; push(E_PH2, "R9"); step(); clear_req = 1'b0;
    for (int i = 0; i < 3; i++) begin push(E_IDLE, "R9"); step(); end
    wake(1);
    while (exp_q.size() > 0) @(negedge clk);
    #1;
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule